// File: doc/BRIEF.md
# Floppy Write and Erase Gate Controller

This block sequences the digital control side of writing to a two-sided flexible-disk head. It qualifies the host write gate, which may be refused while the supply is low, and starts a write from it. Each write-data pulse reverses the direction of the write-driver pair. Tunnel erase is switched on and off later than the write, by counted delays that cover the distance between the read/write core and the erase cores. The block also drives the two head common taps according to the side selected and the operating mode, and it selects the write-current range and the read filter from the current track and the drive model.

The analog current sources and the head drivers stay outside. The block presents their control states as registered digital outputs, and it counts its delays on a fixed-frequency clock. The low-voltage condition arrives as two comparator inputs, one for the lower threshold and one for the upper threshold. The block keeps that condition in a hysteresis flag, and while the flag is set the whole sequence is held in reset.

Top module: `fwe_gate_top`

## Requirements
- R1: After reset with the gate low and side 0 selected, writeEn, eraseEn, drvA, drvB, lowVolt and hiCurrent are all 0. comTap0 reads mid (2'b01) and comTap1 reads low (2'b00).
- R2: writeEn goes to 1 at the clock edge that first samples writeGate high after it was low. It goes to 0 at the first edge that samples writeGate low.
- R3: While writeEn is 1, exactly one of drvA and drvB is 1. Each edge that samples writePulse high swaps the two. While writeEn is 0, both are 0.
- R4: Every write starts with drvA = 1 and drvB = 0, which is the parked direction (FINAL_DIR = 0), however many pulses the previous write had.
- R5: eraseEn rises exactly ERASE_ON cycles after writeEn rises. ERASE_ON is 12 for models 2'b00, 2'b01 and 2'b11, and 9 for model 2'b10 (the high-density model).
- R6: eraseEn falls exactly ERASE_OFF cycles after writeEn falls. ERASE_OFF is 20 for the standard models and 15 for model 2'b10.
- R7: A write shorter than the on delay never turns erase on. If the gate is raised again within the off delay, eraseEn stays 1 with no gap.
- R8: Tap levels are 2'b00 low, 2'b01 mid and 2'b10 high. The tap of the selected side (sideSel 0 selects comTap0) is high during a write and mid otherwise. The tap of the other side is low.
- R9: hiCurrent is 1, one cycle after the inputs are sampled, only on 96 tpi models (2'b01, 2'b10) at tracks 0 to 43. It is 0 at tracks 44 and above, and it is always 0 on models 2'b00 and 2'b11 (48 tpi).
- R10: filterOn follows the same model and track rule as hiCurrent (96 tpi models, tracks 0 to 43), with the same one-cycle latency.
- R11: An edge that samples lvAssert high sets lowVolt and clears writeEn, eraseEn, drvA and drvB at that edge. lvAssert wins over lvRelease. An edge that samples lvRelease high with lvAssert low clears lowVolt.
- R12: A write gate that is already high, or that rises while lowVolt is set, does not start a write. Only a fresh rising gate edge after lowVolt has cleared starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency clock for all registers and delays |
| rstN | input | 1 | Active-low synchronous reset |
| writeGate | input | 1 | Host write gate, active high |
| sideSel | input | 1 | Head side select, 0 or 1 |
| writePulse | input | 1 | One-cycle strobe per write-data pulse |
| trackNum | input | 7 | Current head track number |
| modelSel | input | 2 | Drive model: 00 48 tpi, 01 96 tpi, 10 96 tpi high density, 11 48 tpi |
| lvAssert | input | 1 | Supply below the lower threshold |
| lvRelease | input | 1 | Supply above the upper threshold |
| writeEn | output | 1 | Qualified write in progress |
| lowVolt | output | 1 | Low-voltage hysteresis flag |
| drvA | output | 1 | Write driver A on |
| drvB | output | 1 | Write driver B on |
| eraseEn | output | 1 | Tunnel erase driver enable |
| comTap0 | output | 2 | Side 0 common tap level |
| comTap1 | output | 2 | Side 1 common tap level |
| hiCurrent | output | 1 | Outer-track write current range select |
| filterOn | output | 1 | Read low-pass filter switch |

## Verification
If the erase counter holds a wrong value, the failure shows at the port as an eraseEn edge that lands a few cycles too early or too late compared with writeEn. The edge distance is therefore measured cycle by cycle for each delay set. If the direction latch is in the wrong state, drvA and drvB come out swapped on the very next cycle of a write. For that reason the start polarity and the parity after each random pulse are both checked. A low-voltage flag that is lost or is cleared too early lets writeEn rise on a held gate within one cycle, so the gate is held through the release and then watched.

// File: rtl/fwe_pkg.sv
package fwe_pkg;

  typedef enum logic [1:0] {
    MODEL_48   = 2'b00,
    MODEL_96   = 2'b01,
    MODEL_96HD = 2'b10,
    MODEL_ALT  = 2'b11
  } model_e;

  localparam logic [1:0] TAP_LOW  = 2'b00;
  localparam logic [1:0] TAP_MID  = 2'b01;
  localparam logic [1:0] TAP_HIGH = 2'b10;

  typedef struct packed {
    logic wrActive;
    logic pulseTake;
    logic dirPark;
  } fwe_strobe_t;

endpackage

// File: rtl/fwe_gate_ctrl.sv
module fwe_gate_ctrl
  import fwe_pkg::*;
#(
  parameter int ERASE_ON_STD  = 12,
  parameter int ERASE_OFF_STD = 20,
  parameter int ERASE_ON_HD   = 9,
  parameter int ERASE_OFF_HD  = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        writeGate,
  input  logic        writePulse,
  input  logic [1:0]  modelSel,
  input  logic        lvAssert,
  input  logic        lvRelease,
  output logic        writeEn,
  output logic        lowVolt,
  output logic        eraseEn,
  output fwe_strobe_t strobe
);

  localparam int MAX_ON  = (ERASE_ON_STD > ERASE_ON_HD) ? ERASE_ON_STD : ERASE_ON_HD;
  localparam int MAX_OFF = (ERASE_OFF_STD > ERASE_OFF_HD) ? ERASE_OFF_STD : ERASE_OFF_HD;
  localparam int MAX_D   = (MAX_ON > MAX_OFF) ? MAX_ON : MAX_OFF;
  localparam int CNT_W   = $clog2(MAX_D + 1);

  localparam logic [CNT_W-1:0] ON_STD_C  = CNT_W'(ERASE_ON_STD);
  localparam logic [CNT_W-1:0] OFF_STD_C = CNT_W'(ERASE_OFF_STD);
  localparam logic [CNT_W-1:0] ON_HD_C   = CNT_W'(ERASE_ON_HD);
  localparam logic [CNT_W-1:0] OFF_HD_C  = CNT_W'(ERASE_OFF_HD);

  logic             gatePrev;
  logic             gateRise;
  logic             lvHit;
  logic             hdModel;
  logic [CNT_W-1:0] delayCnt;
  logic [CNT_W-1:0] delayLast;

  assign gateRise = writeGate & ~gatePrev;
  assign lvHit    = lvAssert | lowVolt;
  assign hdModel  = (modelSel == MODEL_96HD);

  // Pick the delay of the transition that is pending: turning on when erase is off.
  always_comb begin
    if (!eraseEn) delayLast = (hdModel ? ON_HD_C : ON_STD_C) - 1'b1;
    else          delayLast = (hdModel ? OFF_HD_C : OFF_STD_C) - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gatePrev <= 1'b0;
      lowVolt  <= 1'b0;
      writeEn  <= 1'b0;
      eraseEn  <= 1'b0;
      delayCnt <= '0;
    end else begin
      gatePrev <= writeGate;

      if (lvAssert)       lowVolt <= 1'b1;
      else if (lvRelease) lowVolt <= 1'b0;

      if (lvHit || !writeGate) writeEn <= 1'b0;
      else if (gateRise)       writeEn <= 1'b1;

      if (lvHit) begin
        eraseEn  <= 1'b0;
        delayCnt <= '0;
      end else if (writeEn != eraseEn) begin
        if (delayCnt == delayLast) begin
          eraseEn  <= writeEn;
          delayCnt <= '0;
        end else begin
          delayCnt <= delayCnt + 1'b1;
        end
      end else begin
        delayCnt <= '0;
      end
    end
  end

  always_comb begin
    strobe.wrActive  = writeEn;
    strobe.pulseTake = writeEn & writePulse;
    strobe.dirPark   = ~writeEn | lvHit;
  end

endmodule

// File: rtl/fwe_gate_dpath.sv
module fwe_gate_dpath
  import fwe_pkg::*;
#(
  parameter int TRACK_W    = 7,
  parameter int OUTER_LAST = 43,
  parameter bit FINAL_DIR  = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  fwe_strobe_t        strobe,
  input  logic               sideSel,
  input  logic [TRACK_W-1:0] trackNum,
  input  logic [1:0]         modelSel,
  output logic               drvA,
  output logic               drvB,
  output logic [1:0]         comTap0,
  output logic [1:0]         comTap1,
  output logic               hiCurrent,
  output logic               filterOn
);

  localparam logic [TRACK_W-1:0] OUTER_C = TRACK_W'(OUTER_LAST);
  localparam int SIDES = 2;

  logic       dirLatch;
  logic       outerZone;
  logic [1:0] tapLevel [SIDES];

  always_ff @(posedge clk) begin
    if (!rstN)                 dirLatch <= FINAL_DIR;
    else if (strobe.dirPark)   dirLatch <= FINAL_DIR;
    else if (strobe.pulseTake) dirLatch <= ~dirLatch;
  end

  assign drvA = strobe.wrActive & ~dirLatch;
  assign drvB = strobe.wrActive & dirLatch;

  for (genvar s = 0; s < SIDES; s++) begin : g_tap
    always_comb begin
      if (sideSel != 1'(s))     tapLevel[s] = TAP_LOW;
      else if (strobe.wrActive) tapLevel[s] = TAP_HIGH;
      else                      tapLevel[s] = TAP_MID;
    end
  end

  assign comTap0 = tapLevel[0];
  assign comTap1 = tapLevel[1];

  assign outerZone = ((modelSel == MODEL_96) || (modelSel == MODEL_96HD)) &&
                     (trackNum <= OUTER_C);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCurrent <= 1'b0;
      filterOn  <= 1'b0;
    end else begin
      hiCurrent <= outerZone;
      filterOn  <= outerZone;
    end
  end

endmodule

// File: rtl/fwe_gate_top.sv
module fwe_gate_top
  import fwe_pkg::*;
#(
  parameter int TRACK_W       = 7,
  parameter int OUTER_LAST    = 43,
  parameter int ERASE_ON_STD  = 12,
  parameter int ERASE_OFF_STD = 20,
  parameter int ERASE_ON_HD   = 9,
  parameter int ERASE_OFF_HD  = 15,
  parameter bit FINAL_DIR     = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               writeGate,
  input  logic               sideSel,
  input  logic               writePulse,
  input  logic [TRACK_W-1:0] trackNum,
  input  logic [1:0]         modelSel,
  input  logic               lvAssert,
  input  logic               lvRelease,
  output logic               writeEn,
  output logic               lowVolt,
  output logic               drvA,
  output logic               drvB,
  output logic               eraseEn,
  output logic [1:0]         comTap0,
  output logic [1:0]         comTap1,
  output logic               hiCurrent,
  output logic               filterOn
);

  fwe_strobe_t strobe;

  fwe_gate_ctrl #(
    .ERASE_ON_STD (ERASE_ON_STD),
    .ERASE_OFF_STD(ERASE_OFF_STD),
    .ERASE_ON_HD  (ERASE_ON_HD),
    .ERASE_OFF_HD (ERASE_OFF_HD)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .writeGate (writeGate),
    .writePulse(writePulse),
    .modelSel  (modelSel),
    .lvAssert  (lvAssert),
    .lvRelease (lvRelease),
    .writeEn   (writeEn),
    .lowVolt   (lowVolt),
    .eraseEn   (eraseEn),
    .strobe    (strobe)
  );

  fwe_gate_dpath #(
    .TRACK_W   (TRACK_W),
    .OUTER_LAST(OUTER_LAST),
    .FINAL_DIR (FINAL_DIR)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sideSel  (sideSel),
    .trackNum (trackNum),
    .modelSel (modelSel),
    .drvA     (drvA),
    .drvB     (drvB),
    .comTap0  (comTap0),
    .comTap1  (comTap1),
    .hiCurrent(hiCurrent),
    .filterOn (filterOn)
  );

endmodule

// File: rtl/fwe_gate_check.sv
module fwe_gate_check #(
  parameter bit FINAL_DIR = 1'b0
) (
  input logic       clk,
  input logic       rstN,
  input logic       writeGate,
  input logic       writeEn,
  input logic       lowVolt,
  input logic       drvA,
  input logic       drvB,
  input logic       eraseEn,
  input logic [1:0] comTap0,
  input logic [1:0] comTap1
);

  a_r3_drivers_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(drvA && drvB));

  a_r3_idle_drivers_off: assert property (@(posedge clk) disable iff (!rstN)
    !writeEn |-> (!drvA && !drvB));

  a_r2_gate_low_ends_write: assert property (@(posedge clk) disable iff (!rstN)
    !writeGate |=> !writeEn);

  a_r4_start_polarity: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeEn) |-> (FINAL_DIR ? drvB : drvA));

  a_r5_erase_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseEn) |-> $past(writeEn));

  a_r11_low_volt_inhibits: assert property (@(posedge clk) disable iff (!rstN)
    lowVolt |-> (!writeEn && !eraseEn));

  a_r12_no_start_when_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeEn) |-> $past(!lowVolt));

  a_r8_one_side_low: assert property (@(posedge clk) disable iff (!rstN)
    (comTap0 == 2'b00) || (comTap1 == 2'b00));

endmodule

bind fwe_gate_top fwe_gate_check #(.FINAL_DIR(FINAL_DIR)) u_fwe_gate_check (
  .clk      (clk),
  .rstN     (rstN),
  .writeGate(writeGate),
  .writeEn  (writeEn),
  .lowVolt  (lowVolt),
  .drvA     (drvA),
  .drvB     (drvB),
  .eraseEn  (eraseEn),
  .comTap0  (comTap0),
  .comTap1  (comTap1)
);

// File: tb/fwe_gate_top_bench.sv
module fwe_gate_top_bench;

  localparam int ON_STD  = 12;
  localparam int OFF_STD = 20;
  localparam int ON_HD   = 9;
  localparam int OFF_HD  = 15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       writeGate = 1'b0;
  logic       sideSel = 1'b0;
  logic       writePulse = 1'b0;
  logic [6:0] trackNum = '0;
  logic [1:0] modelSel = '0;
  logic       lvAssert = 1'b0;
  logic       lvRelease = 1'b0;
  logic       writeEn, lowVolt, drvA, drvB, eraseEn, hiCurrent, filterOn;
  logic [1:0] comTap0, comTap1;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  fwe_gate_top #(
    .TRACK_W(7), .OUTER_LAST(43),
    .ERASE_ON_STD(ON_STD), .ERASE_OFF_STD(OFF_STD),
    .ERASE_ON_HD(ON_HD), .ERASE_OFF_HD(OFF_HD),
    .FINAL_DIR(1'b0)
  ) u_fwe_gate_top (
    .clk(clk), .rstN(rstN), .writeGate(writeGate), .sideSel(sideSel),
    .writePulse(writePulse), .trackNum(trackNum), .modelSel(modelSel),
    .lvAssert(lvAssert), .lvRelease(lvRelease), .writeEn(writeEn),
    .lowVolt(lowVolt), .drvA(drvA), .drvB(drvB), .eraseEn(eraseEn),
    .comTap0(comTap0), .comTap1(comTap1), .hiCurrent(hiCurrent),
    .filterOn(filterOn)
  );

  function automatic int expOn(input logic [1:0] m);
    return (m == 2'b10) ? ON_HD : ON_STD;
  endfunction

  function automatic int expOff(input logic [1:0] m);
    return (m == 2'b10) ? OFF_HD : OFF_STD;
  endfunction

  function automatic int expZone(input logic [1:0] m, input int trk);
    return ((m == 2'b01 || m == 2'b10) && trk <= 43) ? 1 : 0;
  endfunction

  function automatic int expTap(input int side, input int sel, input int wr);
    if (side != sel) return 0;
    return wr ? 2 : 1;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkTaps(input string req);
    check(req, "comTap0", int'(comTap0), expTap(0, int'(sideSel), int'(writeEn)));
    check(req, "comTap1", int'(comTap1), expTap(1, int'(sideSel), int'(writeEn)));
  endtask

  task automatic waitEraseOff();
    for (int i = 0; i < 60 && eraseEn; i++) step();
    step();
  endtask

  // R5 / R6: erase edge spacing from writeEn
  task automatic eraseTiming(input logic [1:0] m);
    int n;
    modelSel = m;
    step();
    writeGate = 1'b1;
    step();
    check("R2", "writeEn rise", int'(writeEn), 1);
    check("R4", "drvA at start", int'(drvA), 1);
    check("R4", "drvB at start", int'(drvB), 0);
    n = 0;
    while (!eraseEn && n < 100) begin step(); n++; end
    check("R5", "erase on delay", n, expOn(m));
    writeGate = 1'b0;
    step();
    check("R2", "writeEn fall", int'(writeEn), 0);
    check("R3", "drivers off after write", int'(drvA | drvB), 0);
    n = 0;
    while (eraseEn && n < 100) begin step(); n++; end
    check("R6", "erase off delay", n, expOff(m));
    step();
  endtask

  initial begin
    int cnt;
    int p;
    int m;
    int t;
    int bad;
    void'($urandom(32'd5150));

    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    check("R1", "writeEn", int'(writeEn), 0);
    check("R1", "eraseEn", int'(eraseEn), 0);
    check("R1", "drvA", int'(drvA), 0);
    check("R1", "drvB", int'(drvB), 0);
    check("R1", "lowVolt", int'(lowVolt), 0);
    check("R1", "hiCurrent", int'(hiCurrent), 0);
    check("R1", "comTap0", int'(comTap0), 1);
    check("R1", "comTap1", int'(comTap1), 0);

    // R5 / R6 for each model
    for (int mm = 0; mm < 4; mm++) eraseTiming(2'(mm));

    // R3 / R8 random pulses during a write
    modelSel = 2'b01;
    writeGate = 1'b1;
    step();
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      p = int'($urandom % 2);
      writePulse = p[0];
      sideSel = 1'($urandom % 2);
      step();
      if (p != 0) cnt++;
      check("R3", "drvA parity", int'(drvA), (cnt % 2 == 0) ? 1 : 0);
      check("R3", "drvB parity", int'(drvB), (cnt % 2 == 1) ? 1 : 0);
      checkTaps("R8");
    end
    writePulse = 1'b0;

    // R7: re-raise within off delay keeps erase on
    check("R7", "erase on before gap", int'(eraseEn), 1);
    writeGate = 1'b0;
    bad = 0;
    for (int i = 0; i < 3; i++) begin step(); if (!eraseEn) bad++; end
    writeGate = 1'b1;
    for (int i = 0; i < 30; i++) begin step(); if (!eraseEn) bad++; end
    check("R7", "erase gaps during re-raise", bad, 0);
    check("R4", "drvA after re-raise", int'(drvA), 1);
    writeGate = 1'b0;
    step();
    waitEraseOff();

    // R7: short write never erases
    modelSel = 2'b00;
    writeGate = 1'b1;
    repeat (4) step();
    writeGate = 1'b0;
    bad = 0;
    for (int i = 0; i < 40; i++) begin step(); if (eraseEn) bad++; end
    check("R7", "erase during short write", bad, 0);

    // R8 idle taps
    for (int i = 0; i < 10; i++) begin
      sideSel = 1'($urandom % 2);
      step();
      checkTaps("R8");
    end

    // R9 / R10 directed boundaries then random
    for (int i = 0; i < 48; i++) begin
      if (i < 8) begin
        m = i % 4;
        t = (i < 4) ? 43 : 44;
      end else begin
        m = int'($urandom % 4);
        t = int'($urandom % 80);
      end
      modelSel = 2'(m);
      trackNum = 7'(t);
      step();
      check("R9", "hiCurrent", int'(hiCurrent), expZone(2'(m), t));
      check("R10", "filterOn", int'(filterOn), expZone(2'(m), t));
    end

    // R11: low voltage during an active erase
    modelSel = 2'b01;
    writeGate = 1'b1;
    repeat (ON_STD + 3) step();
    check("R11", "erase on before lv", int'(eraseEn), 1);
    lvAssert = 1'b1;
    step();
    check("R11", "lowVolt set", int'(lowVolt), 1);
    check("R11", "writeEn cleared", int'(writeEn), 0);
    check("R11", "eraseEn cleared", int'(eraseEn), 0);
    check("R11", "drivers cleared", int'(drvA | drvB), 0);
    lvRelease = 1'b1;
    step();
    check("R11", "assert wins over release", int'(lowVolt), 1);
    lvAssert = 1'b0;
    step();
    check("R11", "release clears", int'(lowVolt), 0);
    lvRelease = 1'b0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin step(); if (writeEn) bad++; end
    check("R12", "held gate ignored after release", bad, 0);
    writeGate = 1'b0;
    step();
    writeGate = 1'b1;
    step();
    check("R12", "fresh edge starts write", int'(writeEn), 1);
    writeGate = 1'b0;
    step();
    waitEraseOff();

    // R12: gate raised while low
    lvAssert = 1'b1;
    step();
    lvAssert = 1'b0;
    writeGate = 1'b1;
    step();
    step();
    lvRelease = 1'b1;
    step();
    lvRelease = 1'b0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin step(); if (writeEn) bad++; end
    check("R12", "gate raised during lv ignored", bad, 0);
    writeGate = 1'b0;
    step();
    writeGate = 1'b1;
    step();
    check("R12", "fresh edge after lv", int'(writeEn), 1);
    writeGate = 1'b0;
    step();
    waitEraseOff();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule